// File: doc/BRIEF.md
# Strobed Parallel Microcontroller Bridge

This block connects an external microcontroller to on-chip logic through an 8-bit bidirectional byte bus. The microcontroller controls every transfer with two pins. A direction pin selects whether it writes bytes into the chip or reads bytes out of it. A strobe pin, slow and irregular, marks each transfer. The strobe never clocks any logic inside the block. The system clock samples it, and each rising edge becomes exactly one single-cycle FIFO operation.

Two synchronous FIFOs, one for each direction, give the on-chip logic a push/pop interface with full and empty flags. Bytes the microcontroller writes land in the inbound FIFO. Bytes the system pushes into the outbound FIFO are presented on the bus one at a time, one per read strobe. A data-ready pin tells the microcontroller that outbound data is waiting. The pad tristate is modelled as a separate output value and output enable. Two sticky flags record a write that was dropped because the inbound FIFO was full, and a read attempted while the outbound FIFO was empty.

Top module: `mcb_bridge`

## Requirements
- R1: With the direction pin low (microcontroller writes), each strobe rising edge pushes exactly one byte into the inbound FIFO: the byte on the bus at that edge. Bytes leave `in_data_o` in arrival order, and `in_pop_i` removes the head byte.
- R2: With the direction pin high (microcontroller reads), each strobe rising edge pops one byte from the outbound FIFO. That byte then appears on `bus_o` and stays there until the next read edge. Bytes come out in the order the system pushed them.
- R3: `data_ready_o` is 1 whenever the outbound FIFO holds at least one byte, and 0 when it is empty.
- R4: `bus_oe_o` is 1 only while the synchronized direction pin indicates a read. Otherwise the bus is released (0).
- R5: A write edge that arrives while the inbound FIFO is full is dropped, and the FIFO contents stay unchanged. `ovf_o` becomes 1 and stays 1 until reset.
- R6: A read edge that arrives while the outbound FIFO is empty leaves `bus_o` unchanged. `unf_o` becomes 1 and stays 1 until reset.
- R7: After the synchronous reset `rst`, both FIFOs are empty, `in_full_o`, `out_full_o`, `ovf_o`, `unf_o`, `bus_oe_o` and `data_ready_o` are all 0, and `bus_o` is 0.
- R8: Each FIFO holds 16 bytes. The full flag rises at the 16th byte. A system push into a full outbound FIFO is ignored.
- R9: A strobe held high for many clocks causes no further transfer. A change of the direction pin with the strobe low causes no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mcu_stb_i | input | 1 | Transfer strobe from the microcontroller, asynchronous |
| mcu_dir_i | input | 1 | Direction from the microcontroller: 1 = read, 0 = write; asynchronous |
| bus_i | input | 8 | Value seen at the bus pads |
| bus_o | output | 8 | Value the block drives onto the bus |
| bus_oe_o | output | 1 | Pad output enable |
| data_ready_o | output | 1 | Outbound FIFO not empty |
| in_pop_i | input | 1 | System pop of the inbound FIFO |
| in_data_o | output | 8 | Head byte of the inbound FIFO |
| in_empty_o | output | 1 | Inbound FIFO empty |
| in_full_o | output | 1 | Inbound FIFO full |
| out_push_i | input | 1 | System push into the outbound FIFO |
| out_data_i | input | 8 | Byte to push into the outbound FIFO |
| out_full_o | output | 1 | Outbound FIFO full |
| out_empty_o | output | 1 | Outbound FIFO empty |
| ovf_o | output | 1 | Sticky flag: a write was dropped |
| unf_o | output | 1 | Sticky flag: a read found no data |

## Verification
The assertions assume three things about the microcontroller's pins. The direction pin and the bus data are stable for at least two system clocks before a strobe rising edge. The strobe stays high, and then low, long enough for the three-flop sampler to see each level. The system side pops only when the inbound FIFO is non-empty.

The stimulus keeps within these limits. It sets direction and data three clocks before raising the strobe, and holds the strobe high for at least four clocks and low for four. It drives every pin on the falling clock edge.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  // Circular pointer advance for a FIFO of any depth.
  function automatic int unsigned ptr_advance(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Rising edge from the current and previous sampled level.
  function automatic logic is_rise(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction
endpackage

// File: rtl/mcb_sync.sv
module mcb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mcb_edge.sv
module mcb_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else prev_q <= lvl;
  end

  assign rise = mcb_pkg::is_rise(lvl, prev_q);
endmodule

// File: rtl/mcb_fifo.sv
module mcb_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= AW'(mcb_pkg::ptr_advance(int'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= AW'(mcb_pkg::ptr_advance(int'(rd_ptr), DEPTH));
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mcb_bridge.sv
module mcb_bridge #(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mcu_stb_i,
  input  logic          mcu_dir_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          data_ready_o,
  input  logic          in_pop_i,
  output logic [DW-1:0] in_data_o,
  output logic          in_empty_o,
  output logic          in_full_o,
  input  logic          out_push_i,
  input  logic [DW-1:0] out_data_i,
  output logic          out_full_o,
  output logic          out_empty_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [1:0]    ctl_s;
  logic          stb_s, dir_s, stb_rise;
  logic [DW-1:0] data_s, out_head;
  logic          wr_evt, rd_evt, in_push, out_pop;
  logic [DW-1:0] bus_q;
  logic          ovf_q, unf_q;

  // Control pins and data share the same sampling depth so the captured byte lines up with the edge.
  mcb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst(rst), .d({mcu_dir_i, mcu_stb_i}), .q(ctl_s));
  mcb_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_dat_sync (
    .clk(clk), .rst(rst), .d(bus_i), .q(data_s));

  assign stb_s = ctl_s[0];
  assign dir_s = ctl_s[1];

  mcb_edge u_edge (.clk(clk), .rst(rst), .lvl(stb_s), .rise(stb_rise));

  // Named transfer events, one cycle wide.
  assign wr_evt  = stb_rise & ~dir_s;
  assign rd_evt  = stb_rise & dir_s;
  assign in_push = wr_evt & ~in_full_o;
  assign out_pop = rd_evt & ~out_empty_o;

  mcb_fifo #(.W(DW), .DEPTH(DEPTH)) u_in_fifo (
    .clk(clk), .rst(rst), .push(in_push), .wdata(data_s), .pop(in_pop_i),
    .rdata(in_data_o), .empty(in_empty_o), .full(in_full_o));

  mcb_fifo #(.W(DW), .DEPTH(DEPTH)) u_out_fifo (
    .clk(clk), .rst(rst), .push(out_push_i), .wdata(out_data_i), .pop(out_pop),
    .rdata(out_head), .empty(out_empty_o), .full(out_full_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (out_pop) bus_q <= out_head;
      if (wr_evt && in_full_o) ovf_q <= 1'b1;
      if (rd_evt && out_empty_o) unf_q <= 1'b1;
    end
  end

  assign bus_o        = bus_q;
  assign bus_oe_o     = dir_s;
  assign data_ready_o = ~out_empty_o;
  assign ovf_o        = ovf_q;
  assign unf_o        = unf_q;
endmodule

// File: rtl/mcb_bridge_chk.sv
module mcb_bridge_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          mcu_dir_i,
  input logic [DW-1:0] bus_o,
  input logic          bus_oe_o,
  input logic          data_ready_o,
  input logic          out_push_i,
  input logic          out_full_o,
  input logic          out_empty_o,
  input logic          in_full_o,
  input logic          in_empty_o,
  input logic          ovf_o,
  input logic          unf_o,
  input logic          wr_evt,
  input logic          rd_evt
);
  assert_single_write_R1: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> !wr_evt);

  assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
    rd_evt |=> !rd_evt);

  assert_ready_after_push_R3: assert property (@(posedge clk) disable iff (rst)
    (out_push_i && !out_full_o) |=> data_ready_o);

  assert_oe_only_read_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(mcu_dir_i, 2) |-> !bus_oe_o);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && in_full_o) |=> (ovf_o && in_full_o));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

  assert_underflow_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && out_empty_o) |=> (unf_o && $stable(bus_o)));

  assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    unf_o |=> unf_o);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(in_full_o && in_empty_o) && !(out_full_o && out_empty_o));
endmodule

bind mcb_bridge mcb_bridge_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mcu_dir_i(mcu_dir_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
  .data_ready_o(data_ready_o), .out_push_i(out_push_i), .out_full_o(out_full_o),
  .out_empty_o(out_empty_o), .in_full_o(in_full_o), .in_empty_o(in_empty_o),
  .ovf_o(ovf_o), .unf_o(unf_o), .wr_evt(wr_evt), .rd_evt(rd_evt));

// File: tb/mcb_bridge_bench.sv
module mcb_bridge_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mcu_stb_i = 1'b0, mcu_dir_i = 1'b0;
  logic [7:0] bus_i = 8'h00;
  logic [7:0] bus_o, in_data_o, out_data_i = 8'h00;
  logic       bus_oe_o, data_ready_o, in_pop_i = 1'b0, in_empty_o, in_full_o;
  logic       out_push_i = 1'b0, out_full_o, out_empty_o, ovf_o, unf_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] exp_in[$];
  logic [7:0] exp_out[$];

  always #4 clk = ~clk;

  mcb_bridge u_mcb_bridge (
    .clk(clk), .rst(rst), .mcu_stb_i(mcu_stb_i), .mcu_dir_i(mcu_dir_i), .bus_i(bus_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o), .data_ready_o(data_ready_o),
    .in_pop_i(in_pop_i), .in_data_o(in_data_o), .in_empty_o(in_empty_o),
    .in_full_o(in_full_o), .out_push_i(out_push_i), .out_data_i(out_data_i),
    .out_full_o(out_full_o), .out_empty_o(out_empty_o), .ovf_o(ovf_o), .unf_o(unf_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one strobe transfer from the microcontroller side.
  task automatic mcu_xfer(input logic dir, input logic [7:0] d, input int hold);
    @(negedge clk);
    mcu_dir_i = dir;
    bus_i = d;
    repeat (3) @(negedge clk);
    mcu_stb_i = 1'b1;
    repeat (hold) @(negedge clk);
    mcu_stb_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic mcu_write(input logic [7:0] d, input bit expect_kept);
    if (expect_kept) exp_in.push_back(d);
    mcu_xfer(1'b0, d, 5);
  endtask

  // Monitor: drains inbound FIFO and compares with the scoreboard queue (R1, R5).
  task automatic drain_in(input string req);
    logic [7:0] e;
    while (!in_empty_o) begin
      if (exp_in.size() == 0) begin
        check(0, req, in_data_o, 0);
      end else begin
        e = exp_in.pop_front();
        check(in_data_o == e, req, in_data_o, e);
      end
      in_pop_i = 1'b1;
      @(negedge clk);
      in_pop_i = 1'b0;
      @(negedge clk);
    end
    check(exp_in.size() == 0, req, exp_in.size(), 0);
    exp_in.delete();
  endtask

  task automatic sys_push(input logic [7:0] d, input bit expect_kept);
    if (expect_kept) exp_out.push_back(d);
    @(negedge clk);
    out_data_i = d;
    out_push_i = 1'b1;
    @(negedge clk);
    out_push_i = 1'b0;
  endtask

  // Read one byte on the bus and compare with the scoreboard (R2).
  task automatic mcu_read_check();
    logic [7:0] e;
    e = exp_out.pop_front();
    mcu_xfer(1'b1, 8'h00, 5);
    check(bus_o == e, "R2 read byte", bus_o, e);
    check(bus_oe_o == 1'b1, "R4 oe during read", bus_oe_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] last;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check(in_empty_o && out_empty_o, "R7 empty", {in_empty_o, out_empty_o}, 3);
    check(!in_full_o && !out_full_o, "R7 full", {in_full_o, out_full_o}, 0);
    check(!ovf_o && !unf_o, "R7 sticky", {ovf_o, unf_o}, 0);
    check(!bus_oe_o && !data_ready_o, "R7 oe/ready", {bus_oe_o, data_ready_o}, 0);
    check(bus_o == 8'h00, "R7 bus", bus_o, 0);

    // R1 basic writes, varied patterns, including a very long strobe (R9)
    mcu_write(8'hA5, 1);
    mcu_write(8'h3C, 1);
    exp_in.push_back(8'hFF);
    mcu_xfer(1'b0, 8'hFF, 40);
    check(bus_oe_o == 1'b0, "R4 oe released on write", bus_oe_o, 0);
    drain_in("R1 inbound order");

    // R9 direction toggling with strobe low: no transfer
    repeat (4) begin
      @(negedge clk); mcu_dir_i = ~mcu_dir_i;
      repeat (3) @(negedge clk);
    end
    mcu_dir_i = 1'b0;
    repeat (3) @(negedge clk);
    check(in_empty_o == 1'b1, "R9 no write without strobe", in_empty_o, 1);
    check(unf_o == 1'b0, "R9 no read without strobe", unf_o, 0);

    // R8/R5 fill inbound to 16 then overflow
    for (int i = 0; i < 16; i++) mcu_write(8'(8'h10 + i), 1);
    check(in_full_o == 1'b1, "R8 inbound full at 16", in_full_o, 1);
    check(ovf_o == 1'b0, "R5 no ovf before extra", ovf_o, 0);
    mcu_write(8'hEE, 0);
    check(ovf_o == 1'b1, "R5 ovf set", ovf_o, 1);
    drain_in("R5 contents kept");
    check(ovf_o == 1'b1, "R5 ovf sticky", ovf_o, 1);

    // R3 data ready
    check(data_ready_o == 1'b0, "R3 ready low when empty", data_ready_o, 0);
    for (int i = 0; i < 16; i++) sys_push(8'(8'hC0 ^ (i * 7)), 1);
    sys_push(8'h99, 0);
    @(negedge clk);
    check(out_full_o == 1'b1, "R8 outbound full at 16", out_full_o, 1);
    check(data_ready_o == 1'b1, "R3 ready high", data_ready_o, 1);

    // R2 reads in order; extra push ignored (R8)
    for (int i = 0; i < 16; i++) mcu_read_check();
    check(data_ready_o == 1'b0, "R3 ready low after reads", data_ready_o, 0);
    check(unf_o == 1'b0, "R6 no unf yet", unf_o, 0);

    // R6 underflow
    last = bus_o;
    mcu_xfer(1'b1, 8'h00, 30);
    check(bus_o == last, "R6 bus unchanged", bus_o, last);
    check(unf_o == 1'b1, "R6 unf set", unf_o, 1);

    // R4 release after switching back to write
    mcu_dir_i = 1'b0;
    repeat (4) @(negedge clk);
    check(bus_oe_o == 1'b0, "R4 oe released", bus_oe_o, 0);
    check(unf_o == 1'b1, "R6 unf sticky", unf_o, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule